// File: doc/BRIEF.md
# Byte-Lane Bus Memory Slave

A 256-byte memory that answers as a slave on a 32-bit big-endian processor bus. Each request carries a 32-bit address, a two-bit transfer-size code, a direction bit and write data. The block compares the upper address bits against a fixed base window. It takes the word index from the middle address bits. From the two lowest address bits and the size code it works out which of the four byte lanes take part in the transfer.

Storage is four byte-wide lane arrays of 64 entries each. A write updates only the selected lanes. A read returns the stored bytes on the selected lanes and zero on all other lanes. For every accepted request, a one-cycle acknowledge appears in the cycle after the request is sampled. Read data and per-lane drive enables are valid in that same cycle. The bus only ever presents aligned transfers, so no alignment checking is done. There is no burst or arbitration support.

Top module: `bmem_slave`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ack_o, rdata_o and lane_oe_o are all zero.
- R2: A request whose address falls outside 0x03300000..0x033000FF gets no acknowledge and changes no stored byte.
- R3: A request sampled at a clock edge with an in-window address and a valid size code produces ack_o high for exactly the following cycle. A cycle with req_i low at the previous edge has ack_o low.
- R4: Size code 2'b01 (byte) writes only the lane chosen by addr_i[1:0]. The other three bytes of that word keep their values.
- R5: Size code 2'b10 (halfword) writes lanes 0-1 when addr_i[1] is 0 and lanes 2-3 when it is 1. The other halfword is kept.
- R6: Size code 2'b00 (word) writes all four lanes of the addressed word.
- R7: The bus is big-endian. The byte at offset k within a word (k = addr_i[1:0]) travels on data bits [31-8k : 24-8k], for both reads and writes.
- R8: On a read acknowledge, rdata_o carries the stored bytes on the selected lanes and zero on the others. lane_oe_o bit k is set exactly when lane k (byte offset k) is selected. Outside an acknowledge, lane_oe_o is zero.
- R9: On the acknowledge of a write, lane_oe_o and rdata_o are zero.
- R10: Size code 2'b11 is reserved. It selects no lane, gets no acknowledge and writes nothing.
- R11: addr_i[7:2] selects one of 64 words, and each word holds its data independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request, sampled each rising edge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | Transfer size: 00 word, 01 byte, 10 halfword, 11 reserved |
| wdata_i | input | 32 | Write data, big-endian lanes |
| ack_o | output | 1 | One-cycle transfer acknowledge |
| rdata_o | output | 32 | Read data, zero on unselected lanes |
| lane_oe_o | output | 4 | Per-lane read drive enable, bit k = byte offset k |

## Verification
On every cycle, the assertions check the following: the acknowledge follows accepted requests and only those; misses and reserved sizes stay silent; lanes not being driven read as zero; writes never drive the lanes; and the lane select has the right number of lanes for each size. Whether the right bytes land in the right word, whether the neighbouring bytes survive a partial write, and whether big-endian placement is correct can only be shown by the bench. It sweeps every byte, halfword and word address against its own byte-array model.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANES  = BUS_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/bmem_decode.sv
module bmem_decode
  import bmem_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        IDX_W     = 6,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h0330_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  xfer_size_e        size_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LANES-1:0]  lane_sel_o
);
  localparam int unsigned TAG_LO = IDX_W + LANE_W;

  logic              win_hit;
  logic [LANES-1:0]  byte_sel;
  logic [1:0]        half_sel;
  logic              word_sel;
  logic [LANE_W-1:0] off;

  assign off     = addr_i[LANE_W-1:0];
  assign win_hit = (addr_i[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
  assign idx_o   = addr_i[TAG_LO-1:LANE_W];

  // separate strobes per size, merged into lane selects below
  always_comb begin
    byte_sel = '0;
    half_sel = '0;
    word_sel = 1'b0;
    unique case (size_i)
      SZ_BYTE: byte_sel[off] = 1'b1;
      SZ_HALF: half_sel[off[1]] = 1'b1;
      SZ_WORD: word_sel = 1'b1;
      default: ;
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_sel_o[k] = byte_sel[k] | half_sel[k/2] | word_sel;
  end

  assign hit_o = win_hit && (size_i != SZ_RSVD);

  always_comb begin
    if (size_i == SZ_BYTE) a_r4_byte_one_lane: assert ($onehot(lane_sel_o));
    if (size_i == SZ_HALF) a_r5_half_two_lanes: assert ($countones(lane_sel_o) == 2 && (lane_sel_o == 4'b0011 || lane_sel_o == 4'b1100));
    if (size_i == SZ_WORD) a_r6_word_all_lanes: assert (&lane_sel_o);
    if (size_i == SZ_RSVD) a_r10_rsvd_no_lane: assert (lane_sel_o == '0 && !hit_o);
  end
endmodule

// File: rtl/bmem_lane.sv
module bmem_lane #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/bmem_rdrive.sv
module bmem_rdrive
  import bmem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [LANES-1:0] lane_sel_i,
  input  logic [BUS_W-1:0] lane_data_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [LANES-1:0] oe_o
);
  logic [LANES-1:0] oe_d;
  logic [BUS_W-1:0] rdata_d;

  assign oe_d = rd_en_i ? lane_sel_i : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_drv
    localparam int unsigned HI = BUS_W - 1 - 8*k;
    assign rdata_d[HI -: 8] = oe_d[k] ? lane_data_i[HI -: 8] : 8'h00;

    a_r8_quiet_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_o[k] |-> rdata_o[HI -: 8] == 8'h00);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= '0;
      rdata_o <= '0;
    end else begin
      oe_o    <= oe_d;
      rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/bmem_slave.sv
module bmem_slave
  import bmem_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       MEM_BYTES = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0330_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              ack_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [LANES-1:0]  lane_oe_o
);
  localparam int unsigned WORDS = MEM_BYTES / LANES;
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] lane_we;
  logic [BUS_W-1:0] lane_rd;
  logic             go;

  bmem_decode #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i    (addr_i),
    .size_i    (xfer_size_e'(size_i)),
    .hit_o     (hit),
    .idx_o     (idx),
    .lane_sel_o(lane_sel)
  );

  assign go = req_i && hit;

  for (genvar k = 0; k < LANES; k++) begin : g_ram
    localparam int unsigned HI = BUS_W - 1 - 8*k;
    assign lane_we[k] = go && we_i && lane_sel[k];
    bmem_lane #(.IDX_W(IDX_W)) u_lane (
      .clk_i  (clk_i),
      .we_i   (lane_we[k]),
      .idx_i  (idx),
      .wdata_i(wdata_i[HI -: 8]),
      .rdata_o(lane_rd[HI -: 8])
    );
  end

  bmem_rdrive u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (go && !we_i),
    .lane_sel_i (lane_sel),
    .lane_data_i(lane_rd),
    .rdata_o    (rdata_o),
    .oe_o       (lane_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= go;
  end

  a_r3_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && hit |=> ack_o);
  a_r3_idle_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  a_r2_miss_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !hit |=> !ack_o);
  a_r8_oe_only_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_oe_o != '0 |-> ack_o);
  a_r9_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |=> lane_oe_o == '0 && rdata_o == '0);
  a_r2_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> lane_we == '0);
endmodule

// File: tb/bmem_slave_test.sv
module bmem_slave_test;
  localparam logic [31:0] BASE = 32'h0330_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic [3:0]  oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  bmem_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .lane_oe_o(oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'b01:   return 4'b0001 << off;
      2'b10:   return off[1] ? 4'b1100 : 4'b0011;
      2'b00:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int word, input logic [3:0] m);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (m[k]) v[31-8*k -: 8] = model[word*4+k];
    return v;
  endfunction

  task automatic xfer(input bit w, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output bit ak,
                      output logic [31:0] rd, output logic [3:0] lo);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    @(negedge clk);
    ak = ack; rd = rdata; lo = oe;
    req = 1'b0;
  endtask

  task automatic do_write(input string tag, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd);
    bit ak; logic [31:0] rd; logic [3:0] lo, m;
    m = mask_of(a[1:0], sz);
    xfer(1'b1, a, sz, wd, ak, rd, lo);
    chk({tag, " ack"}, 32'(ak), 32'd1);
    chk("R9 write oe", 32'(lo), 32'd0);
    chk("R9 write rdata", rd, 32'd0);
    for (int k = 0; k < 4; k++)
      if (m[k]) model[a[7:2]*4+k] = wd[31-8*k -: 8];
  endtask

  task automatic do_read(input string tag, input logic [31:0] a, input logic [1:0] sz);
    bit ak; logic [31:0] rd; logic [3:0] lo, m;
    m = mask_of(a[1:0], sz);
    xfer(1'b0, a, sz, 32'hDEAD_BEEF, ak, rd, lo);
    chk("R3 read ack", 32'(ak), 32'd1);
    chk("R8 lane oe", 32'(lo), 32'(m));
    chk(tag, rd, exp_rd(int'(a[7:2]), m));
  endtask

  task automatic no_ack(input string tag, input logic [31:0] a, input logic [1:0] sz);
    bit ak; logic [31:0] rd; logic [3:0] lo;
    xfer(1'b1, a, sz, 32'hA5A5_A5A5, ak, rd, lo);
    chk(tag, {ak, lo}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ack", 32'(ack), 0);
    chk("R1 reset rdata", rdata, 0);
    chk("R1 reset oe", 32'(oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset ack", 32'(ack), 0);
    chk("R3 idle no ack", {31'd0, ack} | 32'(oe), 0);

    // R6/R11: fill every word with a distinct pattern
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b = 8'(i);
      do_write("R6 word write", BASE + 32'(i*4), 2'b00,
               {b, b ^ 8'h5a, ~b, b + 8'h33});
    end
    for (int i = 0; i < 64; i++) do_read("R11 word readback", BASE + 32'(i*4), 2'b00);

    // R4: one byte per word, lane rotating; word read shows neighbours kept
    for (int i = 0; i < 16; i++) begin
      logic [1:0] o = 2'(i);
      do_write("R4 byte write", BASE + 32'(i*4) + 32'(o), 2'b01, {4{8'hC0 | 8'(i)}});
      do_read("R4 byte neighbours kept", BASE + 32'(i*4), 2'b00);
    end

    // R5: halfword writes alternating halves
    for (int i = 16; i < 32; i++) begin
      logic [1:0] o = {i[0], 1'b0};
      do_write("R5 half write", BASE + 32'(i*4) + 32'(o), 2'b10, {8'h90, 8'(i), 8'h6C, ~8'(i)});
      do_read("R5 half other kept", BASE + 32'(i*4), 2'b00);
    end

    // R7/R8: every byte and halfword address read
    for (int a = 0; a < 256; a++) do_read("R7 byte lane placement", BASE + 32'(a), 2'b01);
    for (int a = 0; a < 256; a += 2) do_read("R8 half lanes", BASE + 32'(a), 2'b10);

    // R2: outside the window
    no_ack("R2 below window no ack", BASE - 32'd4, 2'b00);
    no_ack("R2 above window no ack", BASE + 32'd256, 2'b00);
    no_ack("R2 far alias no ack", BASE ^ 32'h0100_0000, 2'b01);
    do_read("R2 word63 unchanged", BASE + 32'd252, 2'b00);
    do_read("R2 word0 unchanged", BASE, 2'b00);

    // R10: reserved size
    no_ack("R10 reserved no ack", BASE + 32'd20, 2'b11);
    do_read("R10 word5 unchanged", BASE + 32'd20, 2'b00);

    @(negedge clk);
    chk("R3 ack single cycle", 32'(ack), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule